// File: doc/BRIEF.md
# Bit-Addressed Open-Drain I/O Port

This block is an eight-pin general-purpose port whose pins are reached one at a time. A 4-bit pointer value picks the pin, and a small command set acts on it. There are commands to release the pin, to pull it low, to release every pin at once, and to test the pin. The test command raises a skip flag, which lets the core skip its next instruction. Each pin has one latch. A latch value of 1 floats the pin and a latch value of 0 pulls it low, so the pin never drives high. To use a pin as an input, the core first releases it and then reads the external level. That level is seen through a two-stage synchronizer.

A 4-bit pull-up control register sits beside the port. It is loaded from an accumulator value and read back into it. Each bit turns on the pull-ups of one pin pair on a separate pair of ports. All pins come out of reset released and all pull-ups come out of reset off.

Top module: `sel_pin_port`

## Requirements
- R1: After reset every pin is released (pad_oe all 0), pull_en is all 0, and skip, idx_err and acc_valid are 0.
- R2: Command code 1 (release) with idx below 8 sets the addressed latch, so pad_oe[idx] is 0 from the next clock edge. Other pins are unchanged.
- R3: Command code 2 (pull low) with idx below 8 clears the addressed latch, so pad_oe[idx] is 1 from the next clock edge. Other pins are unchanged.
- R4: Command code 3 (release all) sets every latch, so pad_oe is all 0 after the next clock edge.
- R5: Command code 4 (test) reads the addressed pin as latch AND synchronized pad_in. If the read value is 0, skip is 1 for exactly the one cycle after the edge. If the read value is 1, skip stays 0. A pin whose latch is 0 always reads 0.
- R6: pad_in passes through two register stages before a test command sees it. A level change applied before edge k is first seen by a test taken at edge k+2.
- R7: Codes 1, 2 and 4 with idx of 8 or more change no latch and leave skip at 0. They raise idx_err for the one cycle after the edge.
- R8: Command code 5 loads acc_in into the pull-up register. Bit b of that register drives pull_en[2b] and pull_en[2b+1]. Bits 0 and 1 cover pins 0-1 and 2-3 of the first port. Bits 2 and 3 cover pins 0-1 and 2-3 of the second port.
- R9: Command code 6 places the pull-up register value on acc_out, with acc_valid at 1 for the one cycle after the edge. The register value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Command code (0 none, 1 release, 2 pull low, 3 release all, 4 test, 5 pull-up write, 6 pull-up read) |
| idx | input | 4 | Pin pointer value |
| acc_in | input | 4 | Accumulator value for the pull-up write |
| pad_in | input | 8 | Sampled pin levels |
| pad_oe | output | 8 | Per-pin pull-low enable (1 = pin driven low) |
| pull_en | output | 8 | Pull-up enables, two per register bit |
| skip | output | 1 | Skip-next-instruction flag from a test |
| idx_err | output | 1 | Out-of-range pointer flag |
| acc_out | output | 4 | Pull-up register read-back value |
| acc_valid | output | 1 | acc_out is valid |

## Verification
The release and pull-low commands are tried on a walking pattern of pins and on a mixed pattern. These runs show whether the addressed pin is the only one that moves. Tests are taken in three cases: a released pin held high externally, a released pin held low externally, and a pin pulled low by its own latch. Between them these cases separate the latch term from the pad term in the read value. Repeated tests right after a pad change tell a two-stage synchronizer from a shorter or longer one. Out-of-range pointers are applied over a known latch pattern and must leave it intact. Pull-up writes with single-bit and alternating values expose any mix-up in the pair mapping.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_REL    = 3'd1,
        OP_LOW    = 3'd2,
        OP_RELALL = 3'd3,
        OP_TEST   = 3'd4,
        OP_PUWR   = 3'd5,
        OP_PURD   = 3'd6
    } op_e;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_out = st_q.s2;
endmodule

// File: rtl/sp_pullup.sv
module sp_pullup #(
    parameter int PUW = 4,
    parameter int GRP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [PUW-1:0]     wdata,
    output logic [PUW-1:0]     rdata,
    output logic               rvalid,
    output logic [PUW*GRP-1:0] pull_en
);
    typedef struct packed {
        logic [PUW-1:0] pu;
        logic [PUW-1:0] rdat;
        logic           rval;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rval = 1'b0;
        if (wr) st_d.pu = wdata;
        if (rd) begin
            st_d.rdat = st_q.pu;
            st_d.rval = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar b = 0; b < PUW; b++) begin : g_pair
        assign pull_en[b*GRP +: GRP] = {GRP{st_q.pu[b]}};
    end

    assign rdata  = st_q.rdat;
    assign rvalid = st_q.rval;
endmodule

// File: rtl/sel_pin_port.sv
module sel_pin_port #(
    parameter int NPIN = 8,
    parameter int IDXW = 4,
    parameter int PUW  = 4,
    parameter int GRP  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd,
    input  logic [IDXW-1:0]    idx,
    input  logic [PUW-1:0]     acc_in,
    input  logic [NPIN-1:0]    pad_in,
    output logic [NPIN-1:0]    pad_oe,
    output logic [PUW*GRP-1:0] pull_en,
    output logic               skip,
    output logic               idx_err,
    output logic [PUW-1:0]     acc_out,
    output logic               acc_valid
);
    import sp_pkg::*;

    localparam int SELW = $clog2(NPIN);

    typedef struct packed {
        logic [NPIN-1:0] lat;
        logic            skip;
        logic            err;
    } st_t;

    st_t st_d, st_q;

    logic [NPIN-1:0] pad_sync;
    logic [NPIN-1:0] rd_val;
    logic [SELW-1:0] pin;
    logic            in_range;
    op_e             op;
    logic            pu_wr, pu_rd;

    sp_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (pad_sync)
    );

    assign op       = op_e'(cmd);
    assign pin      = idx[SELW-1:0];
    assign in_range = (idx < IDXW'(NPIN));
    assign rd_val   = st_q.lat & pad_sync;
    assign pu_wr    = cmd_valid && (op == OP_PUWR);
    assign pu_rd    = cmd_valid && (op == OP_PURD);

    always_comb begin
        st_d      = st_q;
        st_d.skip = 1'b0;
        st_d.err  = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_REL: begin
                    if (in_range) st_d.lat[pin] = 1'b1;
                    else          st_d.err      = 1'b1;
                end
                OP_LOW: begin
                    if (in_range) st_d.lat[pin] = 1'b0;
                    else          st_d.err      = 1'b1;
                end
                OP_RELALL: st_d.lat = '1;
                OP_TEST: begin
                    if (in_range) st_d.skip = ~rd_val[pin];
                    else          st_d.err  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lat  <= '1;
            st_q.skip <= 1'b0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    sp_pullup #(.PUW(PUW), .GRP(GRP)) u_pu (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (pu_wr),
        .rd      (pu_rd),
        .wdata   (acc_in),
        .rdata   (acc_out),
        .rvalid  (acc_valid),
        .pull_en (pull_en)
    );

    assign pad_oe  = ~st_q.lat;
    assign skip    = st_q.skip;
    assign idx_err = st_q.err;
endmodule

// File: rtl/sel_pin_port_chk.sv
module sel_pin_port_chk #(
    parameter int NPIN = 8,
    parameter int IDXW = 4,
    parameter int PUW  = 4,
    parameter int GRP  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [2:0]         cmd,
    input logic [IDXW-1:0]    idx,
    input logic [PUW-1:0]     acc_in,
    input logic [NPIN-1:0]    pad_oe,
    input logic [PUW*GRP-1:0] pull_en,
    input logic               skip,
    input logic               idx_err
);
    localparam int SELW = $clog2(NPIN);

    logic inr;
    assign inr = (idx < IDXW'(NPIN));

    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == 3'd1 && inr) |=> !pad_oe[$past(idx[SELW-1:0])]);

    a_r3_pull_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == 3'd2 && inr) |=> pad_oe[$past(idx[SELW-1:0])]);

    a_r4_release_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == 3'd3) |=> (pad_oe == '0));

    a_r5_skip_source: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> $past(cmd_valid && cmd == 3'd4));

    a_r7_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd == 3'd1 || cmd == 3'd2) && !inr) |=> (idx_err && $stable(pad_oe)));

    for (genvar b = 0; b < PUW; b++) begin : g_pu
        a_r8_pair_map: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd == 3'd5) |=> (pull_en[b*GRP +: GRP] == {GRP{$past(acc_in[b])}}));
    end
endmodule

bind sel_pin_port sel_pin_port_chk #(.NPIN(NPIN), .IDXW(IDXW), .PUW(PUW), .GRP(GRP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .idx       (idx),
    .acc_in    (acc_in),
    .pad_oe    (pad_oe),
    .pull_en   (pull_en),
    .skip      (skip),
    .idx_err   (idx_err)
);

// File: tb/sel_pin_port_test.sv
module sel_pin_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [3:0] idx = 4'd0;
    logic [3:0] acc_in = 4'd0;
    logic [7:0] ext = 8'hFF;
    logic [7:0] pad_in;
    logic [7:0] pad_oe;
    logic [7:0] pull_en;
    logic       skip, idx_err, acc_valid;
    logic [3:0] acc_out;

    int applied = 0;
    int errs = 0;
    logic [7:0] exp_lat;

    always #4 clk = ~clk;

    assign pad_in = ~pad_oe & ext;

    sel_pin_port uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .idx(idx),
        .acc_in(acc_in), .pad_in(pad_in), .pad_oe(pad_oe), .pull_en(pull_en),
        .skip(skip), .idx_err(idx_err), .acc_out(acc_out), .acc_valid(acc_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; applies a command for one edge, returns at the next negedge.
    task automatic issue(input logic [2:0] c, input logic [3:0] i, input logic [3:0] a);
        cmd_valid = 1'b1; cmd = c; idx = i; acc_in = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 3'd0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(pad_oe == 8'h00, "R1 pad_oe", pad_oe, 0);
        chk(pull_en == 8'h00, "R1 pull_en", pull_en, 0);
        chk({skip, idx_err, acc_valid} == 3'b0, "R1 flags", {skip, idx_err, acc_valid}, 0);
    endtask

    task automatic t_walk;
        for (int p = 0; p < 8; p++) begin
            issue(3'd2, 4'(p), 4'd0);
            exp_lat[p] = 1'b0;
            chk(pad_oe == ~exp_lat, "R3 pull low walk", pad_oe, ~exp_lat);
        end
        for (int p = 0; p < 8; p += 2) begin
            issue(3'd1, 4'(p), 4'd0);
            exp_lat[p] = 1'b1;
            chk(pad_oe == ~exp_lat, "R2 release walk", pad_oe, ~exp_lat);
        end
    endtask

    task automatic t_relall;
        issue(3'd3, 4'd0, 4'd0);
        exp_lat = 8'hFF;
        chk(pad_oe == 8'h00, "R4 release all", pad_oe, 0);
    endtask

    task automatic t_test;
        ext = 8'hFF;
        issue(3'd2, 4'd5, 4'd0);
        exp_lat[5] = 1'b0;
        ext[2] = 1'b0;
        idle(3);
        issue(3'd4, 4'd1, 4'd0);
        chk(skip == 1'b0, "R5 test high pin", skip, 0);
        issue(3'd4, 4'd2, 4'd0);
        chk(skip == 1'b1, "R5 test external low", skip, 1);
        @(negedge clk);
        chk(skip == 1'b0, "R5 skip one cycle", skip, 0);
        issue(3'd4, 4'd5, 4'd0);
        chk(skip == 1'b1, "R5 test latch low", skip, 1);
        ext = 8'hFF;
        issue(3'd1, 4'd5, 4'd0);
        exp_lat[5] = 1'b1;
        idle(3);
    endtask

    task automatic t_sync;
        ext[3] = 1'b0;
        issue(3'd4, 4'd3, 4'd0);
        chk(skip == 1'b0, "R6 edge k old level", skip, 0);
        issue(3'd4, 4'd3, 4'd0);
        chk(skip == 1'b0, "R6 edge k+1 old level", skip, 0);
        issue(3'd4, 4'd3, 4'd0);
        chk(skip == 1'b1, "R6 edge k+2 new level", skip, 1);
        ext = 8'hFF;
        idle(3);
    endtask

    task automatic t_range;
        issue(3'd2, 4'd4, 4'd0);
        exp_lat[4] = 1'b0;
        issue(3'd2, 4'd8, 4'd0);
        chk(idx_err == 1'b1, "R7 err on low", idx_err, 1);
        chk(pad_oe == ~exp_lat, "R7 low ignored", pad_oe, ~exp_lat);
        issue(3'd1, 4'd12, 4'd0);
        chk(pad_oe == ~exp_lat, "R7 release ignored", pad_oe, ~exp_lat);
        issue(3'd4, 4'd15, 4'd0);
        chk({idx_err, skip} == 2'b10, "R7 test ignored", {idx_err, skip}, 2'b10);
        @(negedge clk);
        chk(idx_err == 1'b0, "R7 err one cycle", idx_err, 0);
    endtask

    task automatic t_pullup;
        logic [7:0] e;
        for (int v = 0; v < 4; v++) begin
            issue(3'd5, 4'(1 << v), 4'(1 << v));
            e = 8'(3 << (2 * v));
            chk(pull_en == e, "R8 single bit", pull_en, e);
        end
        issue(3'd5, 4'd0, 4'b1010);
        chk(pull_en == 8'hCC, "R8 alternating", pull_en, 8'hCC);
        issue(3'd6, 4'd0, 4'd0);
        chk(acc_valid && acc_out == 4'b1010, "R9 readback", {acc_valid, acc_out}, 5'h1A);
        chk(pull_en == 8'hCC, "R9 unchanged", pull_en, 8'hCC);
        @(negedge clk);
        chk(acc_valid == 1'b0, "R9 valid one cycle", acc_valid, 0);
    endtask

    initial begin
        exp_lat = 8'hFF;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_walk;
        t_relall;
        t_test;
        t_sync;
        t_range;
        t_pullup;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
        $finish;
    end
endmodule